// File: doc/BRIEF.md
# Byte-Wide Host Bus Engine

This block carries single read and write transactions from an internal core onto an 8-bit external host bus. The core raises a request together with the direction, an address byte and, for writes, a data byte. The engine then drives the external pins. When the transaction ends, it returns a one-cycle acknowledge. For reads, that acknowledge comes with the byte sampled from the bus. If the transaction was abandoned, it comes with an error flag instead.

The engine has four sub-modes. In the multiplexed mode, the address byte goes out on the shared data pins during one address cycle marked by an address-latch pulse, and the data phase follows on the same pins. The demultiplexed and SRAM-style modes put the address on dedicated address pins. FIFO mode also uses dedicated address pins. In addition, it lets an external "transmit empty" flag hold off reads and an external "receive full" flag hold off writes. Each flag has its own enable. A stall limit bounds how long such a hold may last, and a limit of zero means the engine waits without bound.

Read and write wait states are configured separately, and so is the active polarity of each strobe. The core keeps its request raised until it sees the acknowledge, then lowers it.

Top module: `hostbus8_engine`

## Requirements
- R1: After a synchronous reset, both strobes sit at their inactive level, and ack, ack_err, timeout_err, ale and bus_oe are all 0. This also holds when reset lands in the middle of a transaction.
- R2: A read holds its strobe active for exactly cfg_rd_wait+1 consecutive cycles (cfg_rd_wait from 0 to 3), whatever cfg_wr_wait is set to.
- R3: A write holds its strobe active for exactly cfg_wr_wait+1 consecutive cycles (cfg_wr_wait from 0 to 3), whatever cfg_rd_wait is set to. Only one strobe is ever active at a time.
- R4: With cfg_wr_high=0 the write strobe idles at 1 and is active at 0. With cfg_wr_high=1 both levels are inverted.
- R5: With cfg_rd_high=0 the read strobe idles at 1 and is active at 0. With cfg_rd_high=1 both levels are inverted.
- R6: A read returns on rdata, together with ack, the value that bus_din held during the last active cycle of the read strobe.
- R7: bus_oe stays 0 whenever the read strobe is active. During a write strobe, bus_oe is 1 and bus_dout carries the write byte.
- R8: Mode encoding is 0 multiplexed, 1 demultiplexed, 2 SRAM-style and 3 FIFO. In mode 0 there is exactly one cycle with ale=1, bus_oe=1 and bus_dout equal to the address, before the strobe, and ext_addr stays 0. In the other modes ale never rises and ext_addr carries the address while the strobe is active.
- R9: In mode 3 only, a read is held before its strobe while cfg_txe_en and tx_empty are both 1, and a write is held while cfg_rxf_en and rx_full are both 1. A flag whose enable is 0, a flag of the other direction, and any flag in another mode add no cycles.
- R10: If cfg_max_stall is nonzero and a hold lasts cfg_max_stall cycles, the transaction is abandoned without any strobe. The engine then gives ack with ack_err=1 and a one-cycle timeout_err in the same cycle.
- R11: If cfg_max_stall is 0, a hold of any length never times out. The transaction completes normally once the flag clears.
- R12: ack is a one-cycle pulse. It rises cfg_wait+3 clock edges after the request is first seen, counting the accepting edge as the first. Mode 0 adds one edge, and each held cycle adds one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Sub-mode: 0 mux, 1 demux, 2 SRAM-style, 3 FIFO |
| cfg_rd_wait | input | 2 | Read wait states |
| cfg_wr_wait | input | 2 | Write wait states |
| cfg_rd_high | input | 1 | Read strobe is active high when 1 |
| cfg_wr_high | input | 1 | Write strobe is active high when 1 |
| cfg_txe_en | input | 1 | Let tx_empty hold off reads (FIFO mode) |
| cfg_rxf_en | input | 1 | Let rx_full hold off writes (FIFO mode) |
| cfg_max_stall | input | 8 | Stall limit in cycles, 0 means unbounded |
| req | input | 1 | Core transaction request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Transaction address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Transaction was abandoned (valid with ack) |
| rdata | output | 8 | Read byte (valid with ack) |
| bus_dout | output | 8 | Data/address byte driven to the bus |
| bus_oe | output | 1 | Output enable for bus_dout |
| bus_din | input | 8 | Byte received from the bus |
| ext_addr | output | 8 | Dedicated address pins (non-mux modes) |
| ale | output | 1 | Address-latch pulse (mux mode) |
| rd_strb | output | 1 | Read strobe, polarity from cfg_rd_high |
| wr_strb | output | 1 | Write strobe, polarity from cfg_wr_high |
| tx_empty | input | 1 | External transmit-empty flag |
| rx_full | input | 1 | External receive-full flag |
| timeout_err | output | 1 | One-cycle pulse on stall timeout |

## Verification
The embedded assertions check four things on every cycle:
- the two strobes are never active together;
- the output enable is never raised under an active read strobe;
- the address-latch pulse appears only in multiplexed mode;
- acknowledges and timeout pulses last a single cycle, the stall count stays below a nonzero limit, and a timeout always comes with an erroring acknowledge.

Other behaviour can only be shown by the bench's scenarios:
- exact strobe widths for each wait setting, and acknowledge latency;
- which bus_din byte is captured;
- flags being ignored when disabled or outside FIFO mode;
- a 300-cycle hold with no limit completing cleanly.

// File: rtl/hb8_pkg.sv
package hb8_pkg;

    localparam int HB_ADDR_W = 8;
    localparam int HB_DATA_W = 8;

    typedef enum logic [1:0] {
        HB_MUX   = 2'd0,
        HB_DEMUX = 2'd1,
        HB_SRAM  = 2'd2,
        HB_FIFO  = 2'd3
    } hb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_SETUP  = 2'd2,
        ST_STROBE = 2'd3
    } hb_state_e;

    typedef struct packed {
        logic                 wr;
        logic [HB_ADDR_W-1:0] addr;
        logic [HB_DATA_W-1:0] wdata;
    } hb_txn_t;

    // Pin level for a strobe given whether it is active and its polarity.
    function automatic logic strobe_level(input logic active, input logic act_high);
        return ~(active ^ act_high);
    endfunction

endpackage

// File: rtl/hb8_stall_timer.sv
module hb8_stall_timer #(
    parameter int STALL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               hold,
    input  logic [STALL_W-1:0] limit,
    output logic               expire
);
    logic [STALL_W-1:0] cnt;
    logic               limited;

    assign limited = (limit != '0);

    always_ff @(posedge clk) begin
        if (rst || !(run && hold))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expire = run && hold && limited && (cnt == limit - 1'b1);

    // R10
    stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (run && limited) |-> (cnt < limit));

endmodule

// File: rtl/hb8_wait_ctr.sv
module hb8_wait_ctr #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              last
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = run && (cnt == '0);

endmodule

// File: rtl/hb8_pin_drive.sv
module hb8_pin_drive
    import hb8_pkg::*;
(
    input  hb_state_e             state,
    input  hb_txn_t               txn,
    input  logic                  mux_mode,
    input  logic                  rd_high,
    input  logic                  wr_high,
    output logic                  rd_strb,
    output logic                  wr_strb,
    output logic                  ale,
    output logic [HB_DATA_W-1:0]  bus_dout,
    output logic                  bus_oe,
    output logic [HB_ADDR_W-1:0]  ext_addr
);
    logic in_strobe;
    logic rd_act;
    logic wr_act;

    always_comb begin
        in_strobe = (state == ST_STROBE);
        rd_act    = in_strobe && !txn.wr;
        wr_act    = in_strobe && txn.wr;
        rd_strb   = strobe_level(rd_act, rd_high);
        wr_strb   = strobe_level(wr_act, wr_high);
        ale       = (state == ST_ADDR);
        bus_oe    = (state == ST_ADDR) ||
                    (txn.wr && (state == ST_SETUP || state == ST_STROBE));
        bus_dout  = (state == ST_ADDR) ? txn.addr : txn.wdata;
        ext_addr  = (mux_mode || state == ST_IDLE) ? '0 : txn.addr;
    end

endmodule

// File: rtl/hostbus8_engine.sv
module hostbus8_engine
    import hb8_pkg::*;
#(
    parameter int WAIT_W  = 2,
    parameter int STALL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_mode,
    input  logic [WAIT_W-1:0]    cfg_rd_wait,
    input  logic [WAIT_W-1:0]    cfg_wr_wait,
    input  logic                 cfg_rd_high,
    input  logic                 cfg_wr_high,
    input  logic                 cfg_txe_en,
    input  logic                 cfg_rxf_en,
    input  logic [STALL_W-1:0]   cfg_max_stall,
    input  logic                 req,
    input  logic                 req_write,
    input  logic [HB_ADDR_W-1:0] req_addr,
    input  logic [HB_DATA_W-1:0] req_wdata,
    output logic                 ack,
    output logic                 ack_err,
    output logic [HB_DATA_W-1:0] rdata,
    output logic [HB_DATA_W-1:0] bus_dout,
    output logic                 bus_oe,
    input  logic [HB_DATA_W-1:0] bus_din,
    output logic [HB_ADDR_W-1:0] ext_addr,
    output logic                 ale,
    output logic                 rd_strb,
    output logic                 wr_strb,
    input  logic                 tx_empty,
    input  logic                 rx_full,
    output logic                 timeout_err
);
    hb_state_e state;
    hb_txn_t   txn;
    hb_mode_e  mode;
    logic      mux_mode;
    logic      hold;
    logic      expire;
    logic      load_wait;
    logic      last;
    logic [WAIT_W-1:0] wait_sel;

    assign mode     = hb_mode_e'(cfg_mode);
    assign mux_mode = (mode == HB_MUX);
    assign wait_sel = txn.wr ? cfg_wr_wait : cfg_rd_wait;

    always_comb begin
        hold = 1'b0;
        if (mode == HB_FIFO) begin
            if (txn.wr) hold = cfg_rxf_en && rx_full;
            else        hold = cfg_txe_en && tx_empty;
        end
    end

    assign load_wait = (state == ST_SETUP) && !hold;

    hb8_stall_timer #(.STALL_W(STALL_W)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_SETUP),
        .hold   (hold),
        .limit  (cfg_max_stall),
        .expire (expire)
    );

    hb8_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (load_wait),
        .load_val (wait_sel),
        .run      (state == ST_STROBE),
        .last     (last)
    );

    hb8_pin_drive u_pins (
        .state    (state),
        .txn      (txn),
        .mux_mode (mux_mode),
        .rd_high  (cfg_rd_high),
        .wr_high  (cfg_wr_high),
        .rd_strb  (rd_strb),
        .wr_strb  (wr_strb),
        .ale      (ale),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe),
        .ext_addr (ext_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            txn         <= '0;
            ack         <= 1'b0;
            ack_err     <= 1'b0;
            timeout_err <= 1'b0;
            rdata       <= '0;
        end else begin
            ack         <= 1'b0;
            ack_err     <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req && !ack) begin
                        txn.wr    <= req_write;
                        txn.addr  <= req_addr;
                        txn.wdata <= req_wdata;
                        state     <= mux_mode ? ST_ADDR : ST_SETUP;
                    end
                end
                ST_ADDR: state <= ST_SETUP;
                ST_SETUP: begin
                    if (expire) begin
                        ack         <= 1'b1;
                        ack_err     <= 1'b1;
                        timeout_err <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (!hold) begin
                        state <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (last) begin
                        if (!txn.wr) rdata <= bus_din;
                        ack   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !((rd_strb == cfg_rd_high) && (wr_strb == cfg_wr_high)));

    // R7
    rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strb == cfg_rd_high) |-> !bus_oe);

    // R8
    ale_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (cfg_mode == 2'd0));

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R10
    tout_ack_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (ack && ack_err));

    // R10
    tout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);

endmodule

// File: tb/sim_hostbus8_engine.sv
module sim_hostbus8_engine;

    typedef struct packed {
        logic [1:0] mode;
        logic       wr;
        logic [1:0] rdw;
        logic [1:0] wrw;
        logic       rdh;
        logic       wrh;
        logic [7:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 8'h3C, 8'h00},
        '{2'd1, 1'b0, 2'd3, 2'd1, 1'b1, 1'b0, 8'h81, 8'h00},
        '{2'd2, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 8'h47, 8'h5A},
        '{2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 8'hC3, 8'h00},
        '{2'd0, 1'b1, 2'd3, 2'd0, 1'b0, 1'b1, 8'h12, 8'hE7},
        '{2'd3, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 8'h99, 8'h0F},
        '{2'd2, 1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 8'h6E, 8'h00},
        '{2'd0, 1'b1, 2'd0, 2'd3, 1'b1, 1'b0, 8'hF0, 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd1;
    logic [1:0] cfg_rd_wait = '0;
    logic [1:0] cfg_wr_wait = '0;
    logic       cfg_rd_high = 1'b0;
    logic       cfg_wr_high = 1'b0;
    logic       cfg_txe_en = 1'b0;
    logic       cfg_rxf_en = 1'b0;
    logic [7:0] cfg_max_stall = '0;
    logic       req = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ack, ack_err, bus_oe, ale, rd_strb, wr_strb, timeout_err;
    logic [7:0] rdata, bus_dout, ext_addr;
    logic [7:0] bus_din = '0;
    logic       tx_empty = 1'b0;
    logic       rx_full = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hostbus8_engine u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait), .cfg_rd_high(cfg_rd_high), .cfg_wr_high(cfg_wr_high),
        .cfg_txe_en(cfg_txe_en), .cfg_rxf_en(cfg_rxf_en), .cfg_max_stall(cfg_max_stall),
        .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .ack_err(ack_err), .rdata(rdata), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .ext_addr(ext_addr), .ale(ale),
        .rd_strb(rd_strb), .wr_strb(wr_strb), .tx_empty(tx_empty), .rx_full(rx_full),
        .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // One transaction. hold_k >= 0 clears the FIFO flags after k held cycles.
    task automatic run_txn(input vec_t v, input int hold_k, input int exp_lat, input bit exp_err);
        int  n = 0;
        int  rdc = 0, wrc = 0, alec = 0, toc = 0;
        bit  oe_bad = 1'b0, done = 1'b0, wr_ok = 1'b1;
        logic [7:0] ale_byte = '0, strb_addr = '0;
        logic got_err = 1'b0;
        logic [7:0] got_rd = '0;
        @(negedge clk);
        cfg_mode = v.mode; cfg_rd_wait = v.rdw; cfg_wr_wait = v.wrw;
        cfg_rd_high = v.rdh; cfg_wr_high = v.wrh;
        req = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
        while (!done && n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (hold_k >= 0 && n == hold_k + 1) begin
                tx_empty = 1'b0; rx_full = 1'b0;
            end
            if (timeout_err) toc++;
            if (ale) begin alec++; ale_byte = bus_dout; end
            if (rd_strb == cfg_rd_high) begin
                if (bus_oe) oe_bad = 1'b1;
                strb_addr = ext_addr;
                bus_din = 8'hA0 + 8'(rdc);
                rdc++;
            end
            if (wr_strb == cfg_wr_high) begin
                strb_addr = ext_addr;
                if (!bus_oe || bus_dout != v.data) wr_ok = 1'b0;
                wrc++;
            end
            if (ack) begin
                done = 1'b1; got_err = ack_err; got_rd = rdata;
                req = 1'b0;
            end
        end
        chk(n == exp_lat, "R12 latency", n, exp_lat);
        chk(got_err == exp_err, "R10 ack_err", int'(got_err), int'(exp_err));
        chk(toc == (exp_err ? 1 : 0), "R10 timeout pulses", toc, exp_err ? 1 : 0);
        if (exp_err) begin
            chk(rdc + wrc == 0, "R10 no strobe on abort", rdc + wrc, 0);
        end else if (v.wr) begin
            chk(wrc == int'(v.wrw) + 1 && rdc == 0, "R3 write strobe width", wrc, int'(v.wrw) + 1);
            chk(wr_ok, "R7 write data driven", int'(wr_ok), 1);
        end else begin
            chk(rdc == int'(v.rdw) + 1 && wrc == 0, "R2 read strobe width", rdc, int'(v.rdw) + 1);
            chk(got_rd == 8'hA0 + 8'(v.rdw), "R6 read byte", got_rd, 8'hA0 + v.rdw);
            chk(!oe_bad, "R7 oe low in read", int'(oe_bad), 0);
        end
        if (v.mode == 2'd0) begin
            chk(alec == 1 && ale_byte == v.addr, "R8 mux address cycle", ale_byte, v.addr);
            if (!exp_err) chk(strb_addr == 8'h00, "R8 ext_addr idle in mux", strb_addr, 0);
        end else begin
            chk(alec == 0, "R8 no ale", alec, 0);
            if (!exp_err) chk(strb_addr == v.addr, "R8 ext_addr", strb_addr, v.addr);
        end
        @(negedge clk);
        chk(!ack, "R12 ack single cycle", int'(ack), 0);
        chk(rd_strb == !v.rdh, "R5 read strobe idle level", rd_strb, !v.rdh);
        chk(wr_strb == !v.wrh, "R4 write strobe idle level", wr_strb, !v.wrh);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_strb == 1'b1 && wr_strb == 1'b1, "R1 strobes idle", {rd_strb, wr_strb}, 3);
        chk(!ack && !ack_err && !timeout_err, "R1 flags clear", {ack, ack_err, timeout_err}, 0);
        chk(!ale && !bus_oe, "R1 bus idle", {ale, bus_oe}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = TBL[i];
            run_txn(v, -1, 3 + int'(v.wr ? v.wrw : v.rdw) + (v.mode == 2'd0 ? 1 : 0), 1'b0);
        end

        // R9 read held by tx_empty for 4 cycles, limit 10
        d = '{2'd3, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 8'h21, 8'h00};
        cfg_txe_en = 1'b1; cfg_max_stall = 8'd10; tx_empty = 1'b1;
        run_txn(d, 4, 3 + 1 + 4, 1'b0);

        // R9 write ignores tx_empty and a disabled rx_full
        d = '{2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 8'h22, 8'h77};
        cfg_rxf_en = 1'b0; tx_empty = 1'b1; rx_full = 1'b1;
        run_txn(d, -1, 3, 1'b0);

        // R9 flags ignored outside FIFO mode
        d = '{2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 8'h23, 8'h00};
        run_txn(d, -1, 3, 1'b0);
        tx_empty = 1'b0; rx_full = 1'b0;

        // R10 timeout with limit 5
        d = '{2'd3, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 8'h24, 8'h00};
        cfg_max_stall = 8'd5; tx_empty = 1'b1;
        run_txn(d, -1, 6, 1'b1);
        tx_empty = 1'b0;

        // R11 unbounded wait of 300 cycles
        d = '{2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 8'h25, 8'h3E};
        cfg_max_stall = 8'd0; cfg_rxf_en = 1'b1; rx_full = 1'b1;
        run_txn(d, 300, 303, 1'b0);

        // R1 reset in the middle of a read strobe
        @(negedge clk);
        cfg_mode = 2'd1; cfg_rd_wait = 2'd3; cfg_rd_high = 1'b0;
        req = 1'b1; req_write = 1'b0; req_addr = 8'h55;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_strb == 1'b0, "R1 strobe active before reset", rd_strb, 0);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk(rd_strb == 1'b1 && !ack && !bus_oe, "R1 idle after mid reset", {rd_strb, ack, bus_oe}, 4);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule